// File: doc/BRIEF.md
# Serial-Controlled 12-Pin GPIO Expander

This block is a twelve-pin general-purpose I/O port steered by framed 16-bit serial words. A frame opens when the active-low enable falls, collects one bit per rising edge of the serial clock (most significant bit first), and takes effect when the enable rises again. The last four bits of a frame select an operation, and the first twelve carry one bit per pin. Three operations exist: load the output latch, load the direction register, or sample the pin levels into the frame shift register. The shift register's top bit drives the serial output at all times. So after a sample, the pin levels come out during the next frame. Outside a sample, the serial output repeats each frame sixteen clock rises later, which allows several devices to be cascaded.

The serial signals are taken as already synchronous to the system clock; edges are found by comparing with the previous system-clock sample. Pins 4 to 11 are shared with eight DAC channels. A shared pin drives only when its direction bit is set and its paired DAC channel reports high impedance. When both want the pin, a per-pin conflict flag rises. Pads, level shifting and the DAC channels themselves live outside this block.

Top module: `gpio_expander`

## Requirements
- R1: A frame whose address (frame bits 3..0, the last four received) is 4'b1101 copies frame bits 4..15 into the output latch, frame bit 4+j driving pinOut[j], visible one system clock after the enable rise is sampled.
- R2: A frame with address 4'b1111 loads the direction register from frame bits 4..15 with the same bit-to-pin mapping; a 1 makes the pin an output and a 0 makes it an input (pinOe low).
- R3: A frame with address 4'b1110 samples pinIn into shift positions 15..4 on the enable-rise cycle, so serOut shows pinIn[11] at once, then pinIn[10], pinIn[9] and so on, one step after each serial clock rise of the next frame.
- R4: After reset, pinOe and pinOut are all zero, serOut is 0 and no conflict is flagged.
- R5: For shared pin 4+i (i = 0..7, paired with DAC channel 12-i), pinOe[4+i] is the direction bit ANDed with dacHiZ[i]; pins 0..3 follow their direction bits alone.
- R6: pinConflict[i] is high exactly when direction bit 4+i is 1 and dacHiZ[i] is 0.
- R7: Frames with any other address, including the broadcast DAC tri-state code 4'b0000, leave the output latch and direction register unchanged.
- R8: Serial clock rises while the enable is high do not shift the frame register.
- R9: Outside a sample, serOut presents frame bit 15 of the previous frame before the first rise of a frame and then each following bit in order, one per rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serClk | input | 1 | Serial shift clock, synchronous to clk |
| serEnN | input | 1 | Active-low frame enable; rising edge commits |
| serData | input | 1 | Serial data in, most significant bit first |
| serOut | output | 1 | Top bit of the frame shift register |
| pinIn | input | 12 | Levels sampled from the twelve pins |
| pinOut | output | 12 | Output latch value per pin |
| pinOe | output | 12 | Output enable per pin |
| dacHiZ | input | 8 | Bit i high when DAC channel paired with pin 4+i is high impedance |
| pinConflict | output | 8 | Bit i high when pin 4+i is claimed by both owners |

## Verification
A wrong address decode or stray commit corrupts pinOut or pinOe, and that shows at the ports one system clock after the enable rise. A shift register that slips or shifts while the enable is high shows on serOut at the very next frame's first sample, well before any write completes. A sample taken on the wrong cycle or with the wrong bit order shows on serOut before the first serial clock rise of the following frame. An ownership mix-up on the shared pins shows on pinOe and pinConflict as soon as dacHiZ or the direction register changes.

// File: rtl/gpio_expander_pkg.sv
package gpio_expander_pkg;
  localparam int PIN_COUNT    = 12;
  localparam int SHARED_COUNT = 8;
  localparam int ADDR_W       = 4;
  localparam int FRAME_W      = PIN_COUNT + ADDR_W;

  localparam logic [ADDR_W-1:0] ADDR_WR_OUT  = 4'b1101;
  localparam logic [ADDR_W-1:0] ADDR_SAMPLE  = 4'b1110;
  localparam logic [ADDR_W-1:0] ADDR_WR_DIR  = 4'b1111;

  typedef struct packed {
    logic shift;
    logic wrOut;
    logic wrDir;
    logic sample;
  } gpxStrobe_t;
endpackage

// File: rtl/gpio_expander_ctrl.sv
module gpio_expander_ctrl
  import gpio_expander_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              serClk,
  input  logic              serEnN,
  input  logic [ADDR_W-1:0] frameAddr,
  output gpxStrobe_t        stb
);
  logic prevClk;
  logic prevEn;
  logic commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevClk <= 1'b0;
      prevEn  <= 1'b1;
    end else begin
      prevClk <= serClk;
      prevEn  <= serEnN;
    end
  end

  assign commit = serEnN & ~prevEn;

  always_comb begin
    stb        = '0;
    stb.shift  = ~serEnN & serClk & ~prevClk;
    stb.wrOut  = commit & (frameAddr == ADDR_WR_OUT);
    stb.wrDir  = commit & (frameAddr == ADDR_WR_DIR);
    stb.sample = commit & (frameAddr == ADDR_SAMPLE);
  end

  // R8: no shift while the frame enable is high
  p_no_shift_idle_r8: assert property (@(posedge clk) disable iff (rst)
    serEnN |-> !stb.shift);

  // R7: at most one action per cycle, commits only on an enable rise
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.shift, stb.wrOut, stb.wrDir, stb.sample}));

  p_commit_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (stb.wrOut || stb.wrDir || stb.sample) |-> (serEnN && !$past(serEnN)));
endmodule

// File: rtl/gpio_expander_datapath.sv
module gpio_expander_datapath
  import gpio_expander_pkg::*;
#(
  parameter int PINS   = PIN_COUNT,
  parameter int SHARED = SHARED_COUNT,
  parameter int AW     = ADDR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  gpxStrobe_t      stb,
  input  logic            serData,
  input  logic [PINS-1:0] pinIn,
  input  logic [SHARED-1:0] dacHiZ,
  output logic [AW-1:0]   frameAddr,
  output logic            serOut,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinOe,
  output logic [SHARED-1:0] pinConflict
);
  localparam int FW        = PINS + AW;
  localparam int FIRST_SHR = PINS - SHARED;

  logic [FW-1:0]   shiftReg;
  logic [PINS-1:0] outLatch;
  logic [PINS-1:0] dirReg;
  logic [PINS-1:0] payload;

  assign payload   = shiftReg[FW-1:AW];
  assign frameAddr = shiftReg[AW-1:0];
  assign serOut    = shiftReg[FW-1];
  assign pinOut    = outLatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (stb.sample) begin
      shiftReg[FW-1:AW] <= pinIn;
    end else if (stb.shift) begin
      shiftReg <= {shiftReg[FW-2:0], serData};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outLatch <= '0;
      dirReg   <= '0;
    end else begin
      if (stb.wrOut) outLatch <= payload;
      if (stb.wrDir) dirReg   <= payload;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    if (p < FIRST_SHR) begin : g_dedicated
      assign pinOe[p] = dirReg[p];
    end else begin : g_shared
      assign pinOe[p]                   = dirReg[p] & dacHiZ[p-FIRST_SHR];
      assign pinConflict[p-FIRST_SHR]   = dirReg[p] & ~dacHiZ[p-FIRST_SHR];
    end
  end

  // R1: output latch takes the payload on a write
  p_latch_write_r1: assert property (@(posedge clk) disable iff (rst)
    stb.wrOut |=> pinOut == $past(payload));

  // R2: direction register takes the payload on a write
  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    stb.wrDir |=> dirReg == $past(payload));

  // R3: a sample presents the top pin level on the serial output
  p_sample_so_r3: assert property (@(posedge clk) disable iff (rst)
    stb.sample |=> serOut == $past(pinIn[PINS-1]));

  // R4: first cycle out of reset drives nothing
  p_reset_idle_r4: assert property (@(posedge clk)
    $fell(rst) |-> (pinOe == '0 && pinOut == '0));

  // R7: latch and direction hold without their strobe
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !stb.wrOut |=> $stable(pinOut));

  p_dir_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !stb.wrDir |=> $stable(dirReg));

  // R8: frame register holds when neither shifting nor sampling
  p_sr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!stb.shift && !stb.sample) |=> $stable(serOut));
endmodule

// File: rtl/gpio_expander.sv
module gpio_expander
  import gpio_expander_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        serClk,
  input  logic        serEnN,
  input  logic        serData,
  output logic        serOut,
  input  logic [11:0] pinIn,
  output logic [11:0] pinOut,
  output logic [11:0] pinOe,
  input  logic [7:0]  dacHiZ,
  output logic [7:0]  pinConflict
);
  gpxStrobe_t        stb;
  logic [ADDR_W-1:0] frameAddr;

  gpio_expander_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .serClk    (serClk),
    .serEnN    (serEnN),
    .frameAddr (frameAddr),
    .stb       (stb)
  );

  gpio_expander_datapath #(
    .PINS   (PIN_COUNT),
    .SHARED (SHARED_COUNT),
    .AW     (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .serData     (serData),
    .pinIn       (pinIn),
    .dacHiZ      (dacHiZ),
    .frameAddr   (frameAddr),
    .serOut      (serOut),
    .pinOut      (pinOut),
    .pinOe       (pinOe),
    .pinConflict (pinConflict)
  );
endmodule

// File: tb/gpio_expander_tb.sv
module gpio_expander_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        serClk = 1'b0;
  logic        serEnN = 1'b1;
  logic        serData = 1'b0;
  logic        serOut;
  logic [11:0] pinIn = '0;
  logic [11:0] pinOut;
  logic [11:0] pinOe;
  logic [7:0]  dacHiZ = 8'hFF;
  logic [7:0]  pinConflict;

  always #4 clk = ~clk;

  gpio_expander u_dut (
    .clk(clk), .rst(rst), .serClk(serClk), .serEnN(serEnN), .serData(serData),
    .serOut(serOut), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .dacHiZ(dacHiZ), .pinConflict(pinConflict)
  );

  typedef struct {
    string       req;
    int          kind;   // 0 pinOut, 1 pinOe, 2 pinConflict, 3 serOut
    logic [11:0] exp;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic pushExp(input string req, input int kind, input logic [11:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    expQ.push_back(it);
    #1;
  endtask

  // monitor: compares each expected item against the live outputs
  initial begin
    forever begin
      item_t it;
      logic [11:0] act;
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      case (it.kind)
        0: act = pinOut;
        1: act = pinOe;
        2: act = {4'h0, pinConflict};
        default: act = {11'h0, serOut};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends one frame; checks serOut before each of the first soBits rises
  task automatic sendFrame(input logic [15:0] w, input logic [15:0] soExp,
                           input int soBits, input string req);
    serEnN = 1'b0;
    cycles(2);
    for (int k = 0; k < 16; k++) begin
      serData = w[15-k];
      serClk  = 1'b0;
      cycles(2);
      if (k < soBits) pushExp(req, 3, {11'h0, soExp[15-k]});
      serClk = 1'b1;
      cycles(2);
    end
    serClk = 1'b0;
    cycles(2);
    serEnN = 1'b1;
    cycles(2);
  endtask

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(1);
    // R4: reset state
    pushExp("R4", 0, 12'h000);
    pushExp("R4", 1, 12'h000);
    pushExp("R4", 3, 12'h000);
    pushExp("R4", 2, 12'h000);

    // R1: output latch write, R9 not checked yet
    sendFrame({12'hA53, 4'b1101}, 16'h0, 0, "R1");
    pushExp("R1", 0, 12'hA53);
    pushExp("R1", 1, 12'h000);

    // R2: direction write, all outputs with DAC tri-stated
    sendFrame({12'hFFF, 4'b1111}, {12'hA53, 4'b1101}, 16, "R9");
    pushExp("R2", 1, 12'hFFF);
    pushExp("R6", 2, 12'h000);

    // R5/R6: half the DAC channels drive
    dacHiZ = 8'h0F;
    cycles(1);
    pushExp("R5", 1, 12'h0FF);
    pushExp("R6", 2, 12'h0F0);
    dacHiZ = 8'hA5;
    cycles(1);
    pushExp("R5", 1, 12'hA5F);
    pushExp("R6", 2, 12'h05A);
    dacHiZ = 8'hFF;
    cycles(1);

    // R2: partial direction
    sendFrame({12'h0C3, 4'b1111}, 16'h0, 0, "R2");
    pushExp("R2", 1, 12'h0C3);
    pushExp("R1", 0, 12'hA53);

    // R3: sample
    pinIn = 12'hA5C;
    sendFrame({12'h123, 4'b1110}, 16'h0, 0, "R3");
    pushExp("R3", 3, 12'h001);
    pushExp("R7", 0, 12'hA53);
    pinIn = 12'h000;
    cycles(1);

    // R8: stray serial clock rises with the enable high
    for (int k = 0; k < 3; k++) begin
      serData = 1'b0; serClk = 1'b1; cycles(2); serClk = 1'b0; cycles(2);
    end
    pushExp("R8", 3, 12'h001);

    // R3: sampled levels come out during the next frame
    sendFrame({12'h3C6, 4'b1101}, {12'hA5C, 4'b1110}, 12, "R3");
    pushExp("R1", 0, 12'h3C6);

    // R7: broadcast tri-state code, R9 cascade of previous frame
    sendFrame({12'hFFF, 4'b0000}, {12'h3C6, 4'b1101}, 16, "R9");
    pushExp("R7", 0, 12'h3C6);
    pushExp("R7", 1, 12'h0C3);

    // R7: DAC channel address
    sendFrame({12'h000, 4'b0101}, 16'h0, 0, "R7");
    pushExp("R7", 0, 12'h3C6);
    pushExp("R7", 1, 12'h0C3);

    // R1: zero write after nonzero
    sendFrame({12'h000, 4'b1101}, {12'h000, 4'b0101}, 16, "R9");
    pushExp("R1", 0, 12'h000);

    cycles(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule